// File: doc/BRIEF.md
# Converter Power-Up Order Sequencer

This block brings two switching converter rails, core and main, up and down in a fixed order. An order strap picks which rail leads. The leading rail is enabled first and is always the last to go off. Power-up is driven by a level request. The second rail is enabled only after the first rail's power-good input has stayed high for a set number of consecutive cycles. Each waiting phase has a cycle-count timeout that stands in for an analog settle limit.

A timeout during power-up is a fault. It clears both enables and raises a fault flag. When the request drops, the rails are released in reverse order. A low level on the debounced battery-cover input overrides everything. It turns both rails off at once and raises a request that puts the linear regulators into low-power mode.

Two more straps choose the default voltage code for each rail. All straps are captured when the block leaves reset and again at each power-up start. In between they are held. Voltage codes are given in units of 100 mV.

The states, in the order a normal cycle visits them, are:
- ST_OFF: idle.
- ST_RAMP_A: first rail on, waiting for it to settle.
- ST_RAMP_B: both rails on, waiting for the second rail to settle.
- ST_ON: running.
- ST_DROP_B: second rail off, waiting for its power-good to fall.
- ST_DROP_A: first rail off, waiting for its power-good to fall.

Two further states sit outside that cycle:
- ST_FAULT: power-up timeout.
- ST_SHED: cover removed.

The transitions are:
- start: ST_OFF to ST_RAMP_A.
- settle_a: ST_RAMP_A to ST_RAMP_B.
- settle_b: ST_RAMP_B to ST_ON.
- release: ST_ON to ST_DROP_B.
- fall_b: ST_DROP_B to ST_DROP_A.
- fall_a: ST_DROP_A to ST_OFF.
- abort_a: ST_RAMP_A to ST_DROP_A.
- abort_b: ST_RAMP_B to ST_DROP_B.
- stall: a ramp state to ST_FAULT.
- clear: ST_FAULT to ST_OFF.
- shed: any state to ST_SHED.
- rearm: ST_SHED to ST_OFF.

Top module: `psq_sequencer`

## Requirements
- R1: With the order strap at 0, core_en rises before main_en on power-up, and main_en falls before core_en on power-down.
- R2: With the order strap at 1, main_en rises before core_en on power-up, and core_en falls before main_en on power-down.
- R3: The second rail's enable rises on the clock edge at which the first rail's power-good has been high for SETTLE_CYC consecutive edges. rails_ok rises in the same way on the second rail's power-good. A low cycle restarts the count.
- R4: If power-good has not settled after TIMEOUT_CYC edges in a ramp state, fault goes to 1 and both enables go to 0. The fault stays until pwr_req is low, and then the block returns to idle.
- R5: When pwr_req falls in ST_ON, the second rail is disabled on the next edge. The first rail is disabled one edge after the second rail's power-good is seen low, or after TIMEOUT_CYC edges, whichever comes first.
- R6: cover_ok low in any state clears both enables and sets ldo_lp_req on the next edge. ldo_lp_req stays set until cover_ok is high and pwr_req is low.
- R7: core_vcode is 13 when its strap is 0 and 16 when it is 1. main_vcode is 18 when its strap is 0 and 33 when it is 1. Both are 6-bit unsigned codes in units of 100 mV.
- R8: The three straps are captured on the first edge after reset and on the start edge. Strap changes at any other time have no effect on the order or the codes.
- R9: If pwr_req drops during a ramp state, the power-down path is taken from that point. From ST_RAMP_A the first rail goes off. From ST_RAMP_B only the second rail goes off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| order_strap | input | 1 | 0: core leads, 1: main leads |
| core_v_strap | input | 1 | Core default-voltage select |
| main_v_strap | input | 1 | Main default-voltage select |
| pwr_req | input | 1 | High requests the rails on |
| core_pg | input | 1 | Core power-good, synchronous |
| main_pg | input | 1 | Main power-good, synchronous |
| cover_ok | input | 1 | Debounced cover present (low = removed) |
| core_en | output | 1 | Core converter enable |
| main_en | output | 1 | Main converter enable |
| core_vcode | output | 6 | Core default voltage code |
| main_vcode | output | 6 | Main default voltage code |
| ldo_lp_req | output | 1 | Request LDOs into low-power mode |
| fault | output | 1 | Power-up timeout fault |
| rails_ok | output | 1 | Both rails settled |

## Verification
All eight settings of the order and voltage straps are swept. For each, the bench checks which enable leads, the reverse release order and the decoded codes. A power-good glitch partway through the settle count shows whether the count restarts or merely pauses. Holding power-good steady past the limit shows the timeout edge exactly, both in a ramp, where it must fault, and in a drop, where it must not. Cover removal in the running and idle states, and request withdrawal in each ramp state, show whether the override and the abort paths leave the right rail enabled.

// File: rtl/psq_pkg.sv
package psq_pkg;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_RAMP_A,
        ST_RAMP_B,
        ST_ON,
        ST_DROP_B,
        ST_DROP_A,
        ST_FAULT,
        ST_SHED
    } seq_state_t;

endpackage

// File: rtl/psq_strap_latch.sv
module psq_strap_latch #(
    parameter int VW      = 6,
    parameter int CORE_LO = 13,
    parameter int CORE_HI = 16,
    parameter int MAIN_LO = 18,
    parameter int MAIN_HI = 33
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          order_in,
    input  logic          core_sel_in,
    input  logic          main_sel_in,
    output logic          order_q,
    output logic [VW-1:0] core_code,
    output logic [VW-1:0] main_code
);

    localparam logic [VW-1:0] CLO = VW'(CORE_LO);
    localparam logic [VW-1:0] CHI = VW'(CORE_HI);
    localparam logic [VW-1:0] MLO = VW'(MAIN_LO);
    localparam logic [VW-1:0] MHI = VW'(MAIN_HI);

    logic primed_q;
    logic core_sel_q;
    logic main_sel_q;
    logic take;

    assign take = load || !primed_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            primed_q   <= 1'b0;
            order_q    <= 1'b0;
            core_sel_q <= 1'b0;
            main_sel_q <= 1'b0;
        end else begin
            primed_q <= 1'b1;
            if (take) begin
                order_q    <= order_in;
                core_sel_q <= core_sel_in;
                main_sel_q <= main_sel_in;
            end
        end
    end

    always_comb begin
        core_code = core_sel_q ? CHI : CLO;
        main_code = main_sel_q ? MHI : MLO;
    end

endmodule

// File: rtl/psq_timer.sv
module psq_timer #(
    parameter int SETTLE_CYC  = 4,
    parameter int TIMEOUT_CYC = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic pg,
    output logic settled,
    output logic expired
);

    localparam int MAXC = (SETTLE_CYC > TIMEOUT_CYC) ? SETTLE_CYC : TIMEOUT_CYC;
    localparam int CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] S_LAST = CW'(SETTLE_CYC - 1);
    localparam logic [CW-1:0] T_LAST = CW'(TIMEOUT_CYC - 1);

    logic [CW-1:0] good_q;
    logic [CW-1:0] wait_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            good_q <= '0;
            wait_q <= '0;
        end else if (clear) begin
            good_q <= '0;
            wait_q <= '0;
        end else begin
            if (wait_q != T_LAST) begin
                wait_q <= wait_q + 1'b1;
            end
            if (!pg) begin
                good_q <= '0;
            end else if (good_q != S_LAST) begin
                good_q <= good_q + 1'b1;
            end
        end
    end

    assign settled = pg && (good_q == S_LAST);
    assign expired = (wait_q == T_LAST);

endmodule

// File: rtl/psq_fsm.sv
module psq_fsm
    import psq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_req,
    input  logic cover_ok,
    input  logic pg_watch,
    input  logic settled,
    input  logic expired,
    output logic watch_second,
    output logic clear_timer,
    output logic load_straps,
    output logic first_on,
    output logic second_on,
    output logic fault,
    output logic ldo_lp_req,
    output logic rails_ok
);

    seq_state_t state_q;
    seq_state_t state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        if (!cover_ok) begin
            state_d = ST_SHED;
        end else begin
            unique case (state_q)
                ST_OFF:    if (pwr_req)        state_d = ST_RAMP_A;
                ST_RAMP_A: if (!pwr_req)       state_d = ST_DROP_A;
                           else if (settled)   state_d = ST_RAMP_B;
                           else if (expired)   state_d = ST_FAULT;
                ST_RAMP_B: if (!pwr_req)       state_d = ST_DROP_B;
                           else if (settled)   state_d = ST_ON;
                           else if (expired)   state_d = ST_FAULT;
                ST_ON:     if (!pwr_req)       state_d = ST_DROP_B;
                ST_DROP_B: if (!pg_watch || expired) state_d = ST_DROP_A;
                ST_DROP_A: if (!pg_watch || expired) state_d = ST_OFF;
                ST_FAULT:  if (!pwr_req)       state_d = ST_OFF;
                ST_SHED:   if (!pwr_req)       state_d = ST_OFF;
                default:                       state_d = ST_OFF;
            endcase
        end
    end

    always_comb begin
        first_on     = 1'b0;
        second_on    = 1'b0;
        fault        = 1'b0;
        ldo_lp_req   = 1'b0;
        rails_ok     = 1'b0;
        watch_second = 1'b0;
        unique case (state_q)
            ST_OFF:    ;
            ST_RAMP_A: first_on = 1'b1;
            ST_RAMP_B: begin
                first_on     = 1'b1;
                second_on    = 1'b1;
                watch_second = 1'b1;
            end
            ST_ON: begin
                first_on     = 1'b1;
                second_on    = 1'b1;
                rails_ok     = 1'b1;
                watch_second = 1'b1;
            end
            ST_DROP_B: begin
                first_on     = 1'b1;
                watch_second = 1'b1;
            end
            ST_DROP_A: ;
            ST_FAULT:  fault = 1'b1;
            ST_SHED:   ldo_lp_req = 1'b1;
            default:   ;
        endcase
    end

    assign clear_timer = (state_d != state_q);
    assign load_straps = (state_q == ST_OFF) && (state_d == ST_RAMP_A);

endmodule

// File: rtl/psq_sequencer.sv
module psq_sequencer #(
    parameter int VW          = 6,
    parameter int SETTLE_CYC  = 4,
    parameter int TIMEOUT_CYC = 32,
    parameter int CORE_LO     = 13,
    parameter int CORE_HI     = 16,
    parameter int MAIN_LO     = 18,
    parameter int MAIN_HI     = 33
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          order_strap,
    input  logic          core_v_strap,
    input  logic          main_v_strap,
    input  logic          pwr_req,
    input  logic          core_pg,
    input  logic          main_pg,
    input  logic          cover_ok,
    output logic          core_en,
    output logic          main_en,
    output logic [VW-1:0] core_vcode,
    output logic [VW-1:0] main_vcode,
    output logic          ldo_lp_req,
    output logic          fault,
    output logic          rails_ok
);

    logic order_q;
    logic load_straps;
    logic watch_second;
    logic clear_timer;
    logic settled;
    logic expired;
    logic first_on;
    logic second_on;
    logic pg_first;
    logic pg_second;
    logic pg_watch;

    psq_strap_latch #(
        .VW(VW), .CORE_LO(CORE_LO), .CORE_HI(CORE_HI),
        .MAIN_LO(MAIN_LO), .MAIN_HI(MAIN_HI)
    ) u_straps (
        .clk(clk), .rst_n(rst_n), .load(load_straps),
        .order_in(order_strap), .core_sel_in(core_v_strap),
        .main_sel_in(main_v_strap), .order_q(order_q),
        .core_code(core_vcode), .main_code(main_vcode)
    );

    assign pg_first  = order_q ? main_pg : core_pg;
    assign pg_second = order_q ? core_pg : main_pg;
    assign pg_watch  = watch_second ? pg_second : pg_first;

    psq_timer #(
        .SETTLE_CYC(SETTLE_CYC), .TIMEOUT_CYC(TIMEOUT_CYC)
    ) u_timer (
        .clk(clk), .rst_n(rst_n), .clear(clear_timer),
        .pg(pg_watch), .settled(settled), .expired(expired)
    );

    psq_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .pwr_req(pwr_req), .cover_ok(cover_ok),
        .pg_watch(pg_watch), .settled(settled), .expired(expired),
        .watch_second(watch_second), .clear_timer(clear_timer),
        .load_straps(load_straps), .first_on(first_on),
        .second_on(second_on), .fault(fault), .ldo_lp_req(ldo_lp_req),
        .rails_ok(rails_ok)
    );

    assign core_en = order_q ? second_on : first_on;
    assign main_en = order_q ? first_on  : second_on;

endmodule

// File: rtl/psq_checker.sv
module psq_checker #(
    parameter int VW = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cover_ok,
    input logic          order_q,
    input logic          core_en,
    input logic          main_en,
    input logic [VW-1:0] core_vcode,
    input logic [VW-1:0] main_vcode,
    input logic          ldo_lp_req,
    input logic          fault
);

    AST_NO_JOINT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        !($rose(core_en) && $rose(main_en))); // R1

    AST_CORE_LEADS: assert property (@(posedge clk) disable iff (!rst_n)
        (!order_q && $rose(main_en)) |-> core_en); // R1

    AST_MAIN_LEADS: assert property (@(posedge clk) disable iff (!rst_n)
        (order_q && $rose(core_en)) |-> main_en); // R2

    AST_CORE_LAST_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!order_q && $fell(core_en) && cover_ok && !fault) |-> !main_en); // R5

    AST_FAULT_DARK: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (!core_en && !main_en)); // R4

    AST_COVER_SHED: assert property (@(posedge clk) disable iff (!rst_n)
        !cover_ok |=> (!core_en && !main_en && ldo_lp_req)); // R6

    AST_CODES_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (core_en || main_en) |=> ($stable(core_vcode) && $stable(main_vcode))); // R8

endmodule

bind psq_sequencer psq_checker #(.VW(VW)) u_chk (
    .clk(clk), .rst_n(rst_n), .cover_ok(cover_ok), .order_q(order_q),
    .core_en(core_en), .main_en(main_en), .core_vcode(core_vcode),
    .main_vcode(main_vcode), .ldo_lp_req(ldo_lp_req), .fault(fault)
);

// File: tb/sim_psq_sequencer.sv
`timescale 1ns/1ps
module sim_psq_sequencer;

    localparam int SET = 4;
    localparam int TMO = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic order_strap = 1'b0, core_v_strap = 1'b0, main_v_strap = 1'b0;
    logic pwr_req = 1'b0, core_pg = 1'b0, main_pg = 1'b0, cover_ok = 1'b1;
    logic core_en, main_en, ldo_lp_req, fault, rails_ok;
    logic [5:0] core_vcode, main_vcode;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    psq_sequencer u0 (
        .clk(clk), .rst_n(rst_n), .order_strap(order_strap),
        .core_v_strap(core_v_strap), .main_v_strap(main_v_strap),
        .pwr_req(pwr_req), .core_pg(core_pg), .main_pg(main_pg),
        .cover_ok(cover_ok), .core_en(core_en), .main_en(main_en),
        .core_vcode(core_vcode), .main_vcode(main_vcode),
        .ldo_lp_req(ldo_lp_req), .fault(fault), .rails_ok(rails_ok)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // first/second enable as seen for a given order
    function automatic int ens(input bit o);
        return o ? {30'd0, main_en, core_en} : {30'd0, core_en, main_en};
    endfunction

    task automatic set_pg(input bit o, input bit second, input bit v);
        if (o ^ second) main_pg = v; else core_pg = v;
    endtask

    task automatic bring_up(input bit o);
        order_strap = o; pwr_req = 1'b1; step(1);
        set_pg(o, 0, 1); step(SET);
        set_pg(o, 1, 1); step(SET);
    endtask

    initial begin
        step(2);
        rst_n = 1'b1;
        step(1);
        chk("R7 reset core code", core_vcode, 13);
        chk("R7 reset main code", main_vcode, 18);
        chk("R1 reset enables", {core_en, main_en}, 0);
        chk("R4 reset fault", fault, 0);

        // sweep of every strap setting
        for (int k = 0; k < 8; k++) begin
            bit o, cs, ms;
            o = k[2]; cs = k[1]; ms = k[0];
            order_strap = o; core_v_strap = cs; main_v_strap = ms;
            pwr_req = 1'b1; step(1);
            chk(o ? "R2 first rail up" : "R1 first rail up", ens(o), 2);
            chk("R7 core code", core_vcode, cs ? 16 : 13);
            chk("R7 main code", main_vcode, ms ? 33 : 18);
            order_strap = ~o; core_v_strap = ~cs; main_v_strap = ~ms;
            set_pg(o, 0, 1); step(2);
            set_pg(o, 0, 0); step(1);
            set_pg(o, 0, 1); step(SET - 1);
            chk("R3 glitch restarts settle", ens(o), 2);
            step(1);
            chk("R3 second rail after settle", ens(o), 3);
            set_pg(o, 1, 1); step(SET - 1);
            chk("R3 rails_ok before settle", rails_ok, 0);
            step(1);
            chk("R3 rails_ok after settle", rails_ok, 1);
            chk("R8 code held core", core_vcode, cs ? 16 : 13);
            chk("R8 code held main", main_vcode, ms ? 33 : 18);
            pwr_req = 1'b0; step(1);
            chk(o ? "R2 second off first" : "R1 second off first", ens(o), 2);
            set_pg(o, 1, 0); step(1);
            chk("R5 first off after pg low", ens(o), 0);
            set_pg(o, 0, 0); step(1);
            chk("R5 idle", {core_en, main_en, rails_ok}, 0);
        end

        // R8: a new power-up takes the straps present at start
        order_strap = 1; core_v_strap = 1; main_v_strap = 0;
        pwr_req = 1'b1; step(1);
        chk("R8 new order", ens(1), 2);
        chk("R8 new core code", core_vcode, 16);
        pwr_req = 1'b0; step(1); step(1);

        // R4 power-up timeout
        order_strap = 0; pwr_req = 1'b1; step(1);
        step(TMO - 1);
        chk("R4 before timeout", {fault, core_en, main_en}, 3'b010);
        step(1);
        chk("R4 at timeout", {fault, core_en, main_en}, 3'b100);
        step(3);
        chk("R4 fault held", fault, 1);
        pwr_req = 1'b0; step(1);
        chk("R4 fault cleared", fault, 0);

        // R5 power-down timeout with power-good stuck high
        bring_up(1);
        chk("R2 running", rails_ok, 1);
        pwr_req = 1'b0; step(1);
        step(TMO - 1);
        chk("R5 first held before timeout", ens(1), 2);
        step(1);
        chk("R5 first off at timeout", ens(1), 0);
        chk("R5 no fault on drop timeout", fault, 0);
        core_pg = 0; main_pg = 0; step(2);

        // R6 cover removal while running
        bring_up(0);
        cover_ok = 1'b0; step(1);
        chk("R6 both off", {core_en, main_en}, 0);
        chk("R6 ldo request", ldo_lp_req, 1);
        core_pg = 0; main_pg = 0;
        cover_ok = 1'b1; step(2);
        chk("R6 held while request high", ldo_lp_req, 1);
        pwr_req = 1'b0; step(1);
        chk("R6 released", ldo_lp_req, 0);
        cover_ok = 1'b0; step(1);
        chk("R6 cover low in idle", ldo_lp_req, 1);
        cover_ok = 1'b1; step(1);
        chk("R6 idle rearm", ldo_lp_req, 0);

        // R9 abort during ramps
        order_strap = 0; pwr_req = 1'b1; step(1);
        set_pg(0, 0, 1); step(2);
        pwr_req = 1'b0; step(1);
        chk("R9 abort ramp A", {core_en, main_en}, 0);
        set_pg(0, 0, 0); step(1);
        order_strap = 1; pwr_req = 1'b1; step(1);
        set_pg(1, 0, 1); step(SET);
        chk("R9 in ramp B", ens(1), 3);
        pwr_req = 1'b0; step(1);
        chk("R9 abort ramp B keeps first", ens(1), 2);
        step(1);
        chk("R9 first off after second pg low", ens(1), 0);
        core_pg = 0; main_pg = 0; step(2);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule